// File: doc/BRIEF.md
# Multiplexed LCD Backplane and Segment Driver

This block drives a passive liquid-crystal panel directly from digital pins, with one, two or four backplanes. Each backplane pin has an output enable and a data bit. With the enable low the pin is released, and an external divider of two equal resistors holds it at half supply. With the enable high the pin drives 0 or 1. Segment pins always drive a plain logic level. A segment lights when its pin drives the opposite level to the backplane that is active at that moment, and stays dark when it drives the same level. Every backplane spends one slot high and one slot low in each frame, so the voltage across every segment averages to zero.

Software writes the on/off pattern one row at a time into a shadow image. Each row belongs to one backplane, and each bit of a row belongs to one segment pin. The shadow image is copied into the active image only at the start of a frame. A programmable divider sets the slot length, so a frame of 2·M slots can be tuned into the 30–200 Hz range, where M is the multiplex ratio. The controller has two states. In IDLE every backplane is released and every segment drives 0. In RUN the block walks through the slots of the frame. The transitions are:
- IDLE→RUN on enable, which loads the image and the mode.
- RUN→RUN at the end of a frame while enable is held, which reloads the image and the mode.
- RUN→IDLE at the end of a frame once enable has dropped.

Top module: `lcd_mux_drv`

## Requirements
- R1: A backplane with `com_oe`=0 is released (mid-rail), and its `com_dat` bit is then 0. With `com_oe`=1 the `com_dat` bit is the driven level.
- R2: At most one backplane is driven in any cycle. All the others are released.
- R3: `mux_mode` 0 selects 1 backplane, 1 selects 2, and 2 or 3 select 4. A frame has 2·M slots, numbered from 0. Backplane k is driven high in slot 2k and driven low in slot 2k+1. A backplane with no slot in the frame stays released for the whole frame.
- R4: Each slot lasts `slot_div`+1 clock cycles.
- R5: During a slot, segment pin j drives the active backplane's level XOR bit j of that backplane's active row. Bit value 1 means lit, so the pin drives the opposite level.
- R6: A write with `wr_en`=1 stores `wr_bits` into the shadow row `wr_row`. Row k serves backplane k, and bit j serves segment pin j.
- R7: Shadow rows reach the outputs only from the first slot of the next frame, or from slot 0 when the block is started from IDLE. A frame never shows mixed data.
- R8: A change of `mux_mode` takes effect only at a frame start.
- R9: When `enable` drops, the current frame completes. From the next cycle all backplanes are released and all segments drive 0. Raising `enable` in IDLE starts slot 0 in the following cycle.
- R10: During and after reset, the block is in IDLE with all backplanes released and all segment outputs 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run request; sampled at frame ends |
| mux_mode | input | 2 | Multiplex ratio select |
| slot_div | input | PRE_W | Slot length minus one, in clock cycles |
| wr_en | input | 1 | Shadow row write strobe |
| wr_row | input | 2 | Shadow row (backplane) index |
| wr_bits | input | SEG_PINS | Row data, 1 = segment lit |
| com_oe | output | 4 | Backplane output enables, 0 = released to mid-rail |
| com_dat | output | 4 | Backplane drive levels |
| seg_dat | output | SEG_PINS | Segment pin levels |

## Verification
The hardest situation to reach from the ports is a mode change or a row write that lands in the middle of a frame. Such a change must not touch the frame already running, and it must fully apply from the next one. The directed sequence changes the mode from four backplanes to one, and rewrites a row, while a four-backplane frame is in progress. It then checks the last slot of the old frame and the first slots of the new frame. Constrained-random stimulus then toggles enable, mode, divider and writes at arbitrary cycles, so that stops and reloads meet every slot position. A cycle-level model in the bench checks every cycle against these requirements.

// File: rtl/lcd_mux_pkg.sv
package lcd_mux_pkg;
    localparam int COM_LINES = 4;
    localparam int ROW_W     = 2;
    localparam int SLOT_W    = 3;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } drv_state_e;

    function automatic logic [SLOT_W-1:0] final_slot(input logic [1:0] mode);
        unique case (mode)
            2'd0:    final_slot = SLOT_W'(1);
            2'd1:    final_slot = SLOT_W'(3);
            default: final_slot = SLOT_W'(7);
        endcase
    endfunction
endpackage

// File: rtl/lcd_phase_gen.sv
module lcd_phase_gen
    import lcd_mux_pkg::*;
#(
    parameter int PRE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [PRE_W-1:0]  slot_div,
    input  logic [SLOT_W-1:0] last_slot,
    output logic [SLOT_W-1:0] slot,
    output logic              frame_end
);
    logic [PRE_W-1:0] tick_q;
    logic             slot_end;

    assign slot_end  = run && (tick_q >= slot_div);
    assign frame_end = slot_end && (slot == last_slot);

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            tick_q <= '0;
            slot   <= '0;
        end else if (slot_end) begin
            tick_q <= '0;
            slot   <= frame_end ? '0 : slot + 1'b1;
        end else begin
            tick_q <= tick_q + 1'b1;
        end
    end
endmodule

// File: rtl/lcd_seg_store.sv
module lcd_seg_store
    import lcd_mux_pkg::*;
#(
    parameter int SEG_PINS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ROW_W-1:0]    wr_row,
    input  logic [SEG_PINS-1:0] wr_bits,
    input  logic                load,
    input  logic [ROW_W-1:0]    rd_row,
    output logic [SEG_PINS-1:0] rd_bits
);
    logic [SEG_PINS-1:0] shadow_q [COM_LINES];
    logic [SEG_PINS-1:0] active_q [COM_LINES];

    for (genvar r = 0; r < COM_LINES; r++) begin : g_row
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                shadow_q[r] <= '0;
                active_q[r] <= '0;
            end else begin
                if (wr_en && (wr_row == ROW_W'(r)))
                    shadow_q[r] <= wr_bits;
                if (load)
                    active_q[r] <= shadow_q[r];
            end
        end
    end

    assign rd_bits = active_q[rd_row];
endmodule

// File: rtl/lcd_mux_drv.sv
module lcd_mux_drv
    import lcd_mux_pkg::*;
#(
    parameter int SEG_PINS = 8,
    parameter int PRE_W    = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  logic [1:0]           mux_mode,
    input  logic [PRE_W-1:0]     slot_div,
    input  logic                 wr_en,
    input  logic [1:0]           wr_row,
    input  logic [SEG_PINS-1:0]  wr_bits,
    output logic [COM_LINES-1:0] com_oe,
    output logic [COM_LINES-1:0] com_dat,
    output logic [SEG_PINS-1:0]  seg_dat
);
    drv_state_e          state_q, state_d;
    logic [1:0]          mode_q;
    logic [SLOT_W-1:0]   slot;
    logic                frame_end;
    logic                load;
    logic [ROW_W-1:0]    act_row;
    logic                act_level;
    logic [SEG_PINS-1:0] row_bits;

    assign act_row   = slot[SLOT_W-1:1];
    assign act_level = ~slot[0];
    assign load      = enable && ((state_q == ST_IDLE) || frame_end);

    lcd_phase_gen #(.PRE_W(PRE_W)) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (state_q == ST_RUN),
        .slot_div  (slot_div),
        .last_slot (final_slot(mode_q)),
        .slot      (slot),
        .frame_end (frame_end)
    );

    lcd_seg_store #(.SEG_PINS(SEG_PINS)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_row  (wr_row),
        .wr_bits (wr_bits),
        .load    (load),
        .rd_row  (act_row),
        .rd_bits (row_bits)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (enable) state_d = ST_RUN;
            ST_RUN:  if (frame_end && !enable) state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mode_q  <= 2'd0;
        end else begin
            state_q <= state_d;
            if (load) mode_q <= mux_mode;
        end
    end

    always_comb begin
        com_oe  = '0;
        com_dat = '0;
        seg_dat = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RUN: begin
                com_oe[act_row]  = 1'b1;
                com_dat[act_row] = act_level;
                seg_dat          = {SEG_PINS{act_level}} ^ row_bits;
            end
        endcase
    end
endmodule

// File: rtl/lcd_mux_chk.sv
module lcd_mux_chk #(
    parameter int SEG_PINS = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic [3:0]          com_oe,
    input logic [3:0]          com_dat,
    input logic [SEG_PINS-1:0] seg_dat,
    input logic                idle,
    input logic                frame_end
);
    AST_ONE_BACKPLANE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(com_oe)); // R2
    AST_RELEASED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (com_dat & ~com_oe) == 4'b0); // R1
    AST_HIGH_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        ((com_oe & ~$past(com_oe)) & ~com_dat) == 4'b0); // R3
    AST_RUN_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |-> $countones(com_oe) == 1); // R3
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (com_oe == 4'b0 && seg_dat == '0)); // R9
    AST_STOP_AT_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(idle) |-> $past(frame_end)); // R9
endmodule

bind lcd_mux_drv lcd_mux_chk #(.SEG_PINS(SEG_PINS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .com_oe    (com_oe),
    .com_dat   (com_dat),
    .seg_dat   (seg_dat),
    .idle      (state_q == lcd_mux_pkg::ST_IDLE),
    .frame_end (frame_end)
);

// File: tb/lcd_mux_drv_tb_top.sv
module lcd_mux_drv_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int SEG       = 8;
    localparam int PW        = 16;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           enable = 1'b0;
    logic [1:0]     mux_mode = 2'd0;
    logic [PW-1:0]  slot_div = '0;
    logic           wr_en = 1'b0;
    logic [1:0]     wr_row = 2'd0;
    logic [SEG-1:0] wr_bits = '0;
    logic [3:0]     com_oe, com_dat;
    logic [SEG-1:0] seg_dat;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lcd_mux_drv #(.SEG_PINS(SEG), .PRE_W(PW)) dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .mux_mode(mux_mode),
        .slot_div(slot_div), .wr_en(wr_en), .wr_row(wr_row), .wr_bits(wr_bits),
        .com_oe(com_oe), .com_dat(com_dat), .seg_dat(seg_dat)
    );

    // reference model built from the requirements
    logic           m_run;
    logic [PW-1:0]  m_cnt;
    logic [2:0]     m_slot;
    logic [1:0]     m_mode;
    logic [SEG-1:0] m_img [4];
    logic [SEG-1:0] m_shd [4];

    function automatic logic [2:0] m_last(input logic [1:0] md);
        return (md == 2'd0) ? 3'd1 : (md == 2'd1) ? 3'd3 : 3'd7;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_run <= 1'b0; m_cnt <= '0; m_slot <= '0; m_mode <= '0;
            for (int r = 0; r < 4; r++) begin m_img[r] <= '0; m_shd[r] <= '0; end
        end else begin
            if (wr_en) m_shd[wr_row] <= wr_bits;
            if (!m_run) begin
                if (enable) begin
                    m_run <= 1'b1; m_cnt <= '0; m_slot <= '0; m_mode <= mux_mode;
                    for (int r = 0; r < 4; r++) m_img[r] <= m_shd[r];
                end
            end else if (m_cnt >= slot_div) begin
                m_cnt <= '0;
                if (m_slot == m_last(m_mode)) begin
                    m_slot <= '0;
                    if (enable) begin
                        m_mode <= mux_mode;
                        for (int r = 0; r < 4; r++) m_img[r] <= m_shd[r];
                    end else m_run <= 1'b0;
                end else m_slot <= m_slot + 3'd1;
            end else m_cnt <= m_cnt + 1'b1;
        end
    end

    function automatic logic [3:0] exp_oe();
        return m_run ? 4'(4'b0001 << m_slot[2:1]) : 4'b0;
    endfunction
    function automatic logic [3:0] exp_dat();
        return (m_run && !m_slot[0]) ? exp_oe() : 4'b0;
    endfunction
    function automatic logic [SEG-1:0] exp_seg();
        return m_run ? ({SEG{~m_slot[0]}} ^ m_img[m_slot[2:1]]) : '0;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        chk("R3 com_oe", 32'(com_oe), 32'(exp_oe()));
        chk("R1 com_dat", 32'(com_dat), 32'(exp_dat()));
        chk("R5 seg_dat", 32'(seg_dat), 32'(exp_seg()));
        chk("R2 one driven", 32'($countones(com_oe) <= 1), 32'd1);
    endtask

    task automatic put_row(input logic [1:0] r, input logic [SEG-1:0] b);
        wr_en = 1'b1; wr_row = r; wr_bits = b;
        step();
        wr_en = 1'b0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 200000 && !done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=<200000", cyc);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int hi0, lo3;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        chk("R10 reset com_oe", 32'(com_oe), 32'd0);
        chk("R10 reset seg", 32'(seg_dat), 32'd0);
        rst_n = 1'b1;
        step();
        put_row(2'd0, 8'hA5);
        put_row(2'd1, 8'h3C);
        put_row(2'd2, 8'h0F);
        put_row(2'd3, 8'hF0);
        chk("R9 idle before enable", 32'(com_oe), 32'd0);
        mux_mode = 2'd2; slot_div = 16'd4; enable = 1'b1;
        hi0 = 0; lo3 = 0;
        for (int i = 0; i <= 64; i++) begin
            step();
            if (i < 40) begin
                if (com_oe == 4'b0001 && com_dat[0]) hi0++;
                if (com_oe == 4'b1000 && !com_dat[3]) lo3++;
            end
            if (i == 0)  chk("R6 row0 slot0", 32'(seg_dat), 32'h5A);
            if (i == 5)  chk("R7 old row kept", 32'(seg_dat), 32'hA5);
            if (i == 10) chk("R6 row1 slot2", 32'(seg_dat), 32'hC3);
            if (i == 30) chk("R8 old mode slot6", 32'(com_oe), 32'h8);
            if (i == 40) chk("R7 new row at frame", 32'(seg_dat), 32'h7E);
            if (i == 47) chk("R8 new mode slot1", 32'({com_oe, com_dat}), 32'h10);
            if (i == 47) chk("R8 new mode seg", 32'(seg_dat), 32'h81);
            if (i == 50) chk("R8 frame of two slots", 32'({com_oe, com_dat}), 32'h11);
            if (i == 59) chk("R9 frame completes", 32'({com_oe, com_dat}), 32'h10);
            if (i == 60) chk("R9 stopped com", 32'(com_oe), 32'd0);
            if (i == 60) chk("R9 stopped seg", 32'(seg_dat), 32'd0);
            wr_en = (i == 2);
            if (i == 2) begin wr_row = 2'd0; wr_bits = 8'h81; end
            if (i == 12) mux_mode = 2'd0;
            if (i == 51) enable = 1'b0;
        end
        chk("R4 high slot length", 32'(hi0), 32'd5);
        chk("R4 low slot length", 32'(lo3), 32'd5);

        for (int n = 0; n < 20000; n++) begin
            step();
            wr_en = ($urandom_range(3) == 0);
            wr_row = 2'($urandom_range(3));
            wr_bits = SEG'($urandom);
            if ($urandom_range(199) == 0) enable = ~enable;
            if ($urandom_range(99) == 0) mux_mode = 2'($urandom_range(3));
            if ($urandom_range(299) == 0) slot_div = PW'($urandom_range(3));
        end
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule